// File: doc/BRIEF.md
# Active Thread Lane Compaction Unit

This block takes the active-thread mask of a warp and gathers the indices of the active threads, lowest index first, into consecutive lanes of a row of equal-width SIMD sets. The sets are described lane by lane. Placement starts at lane 0 of a set chosen by the caller. That set number is given as an offset, so a second warp can be packed into the sets that a first warp left free. Threads keep their warp order. Gaps between active threads disappear, so a sparse warp occupies as few sets as possible instead of one lane per thread position.

For every set the block reports five things: whether it holds any thread, which of its lanes are occupied, the thread index in each lane, how many threads it holds, and a warp-wide bit mask of those threads. Active threads that do not fit in the sets from the start set onward are discarded, and an overflow flag reports that. The caller pulses a start strobe. The whole result is registered on the next clock edge and then held until the next strobe. The set width is the warp size divided by the number of sets. The count of sets is a parameter, and its default arrangement is four sets of eight lanes for a 32-thread warp.

Top module: `compact_unit`

## Requirements
- R1: After a synchronous reset every output is zero: no set is valid, all lane masks, lane thread IDs, counts and warp-position masks are cleared, and `done` and `overflow` are low.
- R2: A pulse on `start` captures `warp_mask` and `start_set`. The result appears on the outputs after the next rising edge, with `done` high for exactly that one cycle. Without `start`, the outputs hold their values whatever the inputs do.
- R3: Active threads are placed in ascending thread index. The k-th active thread (k counted from 0) goes to global lane `start_set*SET_W + k`, where global lane g is lane `g % SET_W` of set `g / SET_W`, with `SET_W = WARP_SIZE/NUM_SETS`.
- R4: Every set whose index is below `start_set` stays invalid, with an empty lane mask, a zero count, an empty warp-position mask and zero thread IDs.
- R5: Within a set, lanes fill from lane 0 upward, so each lane mask is a run of ones starting at bit 0. A set receives threads only after every earlier set at or above `start_set` holds SET_W threads.
- R6: Each set's count equals the number of its occupied lanes. Its warp-position mask has bit t set exactly when thread t sits in one of its lanes.
- R7: A set is valid exactly when at least one thread was placed in it. An all-zero warp mask gives no valid set.
- R8: Every unoccupied lane reports thread ID 0.
- R9: When the number of active threads exceeds `(NUM_SETS - start_set) * SET_W`, `overflow` is high and the active threads with the highest indices beyond capacity are dropped. Otherwise `overflow` is low.
- R10: Output layout: set s lane l has its mask bit at `lane_mask[s*SET_W+l]` and its thread ID at `lane_tid[(s*SET_W+l)*TID_W +: TID_W]`. Set s has its count at `set_count[s*CNT_W +: CNT_W]` and its warp-position mask at `warp_pos[s*WARP_SIZE +: WARP_SIZE]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for a new compaction |
| warp_mask | input | WARP_SIZE | Active-thread mask, bit t for thread t |
| start_set | input | SIDX_W | Index of the first set to fill |
| done | output | 1 | High for one cycle when a new result is on the outputs |
| set_valid | output | NUM_SETS | Per-set valid flag |
| lane_mask | output | NUM_SETS*SET_W | Per-lane occupied flag |
| lane_tid | output | NUM_SETS*SET_W*TID_W | Thread ID held in each lane |
| set_count | output | NUM_SETS*CNT_W | Number of threads held by each set |
| warp_pos | output | NUM_SETS*WARP_SIZE | Per-set mask of the warp positions it holds |
| overflow | output | 1 | Some active threads did not fit and were dropped |

## Verification
The hardest situation to reach is the boundary where threads spill across a set edge at a non-zero offset. That case needs enough active threads to fill one set, continue into the next and run past the last set, while the sets below the offset must stay empty. The bench reaches it with dense and patterned masks combined with start offsets of 1 to 3. It compares every lane against a model that walks the mask thread by thread. It also reports how many sets the direct one-lane-per-thread mapping would use, so the packing gain is visible. A separate step changes the inputs without a strobe to show that the registered result holds.

// File: rtl/compact_pkg.sv
package compact_pkg;
  function automatic int clog2_min1(input int value);
    int r;
    r = 0;
    while ((1 << r) < value) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/compact_rank.sv
module compact_rank #(
  parameter int WARP_SIZE = 32,
  parameter int RANK_W    = 6
) (
  input  logic [WARP_SIZE-1:0]        mask,
  output logic [WARP_SIZE*RANK_W-1:0] rank_flat,
  output logic [RANK_W-1:0]           total
);
  // Exclusive prefix count: rank of thread t is the number of active threads below t.
  always_comb begin
    logic [RANK_W-1:0] acc;
    acc = '0;
    rank_flat = '0;
    for (int t = 0; t < WARP_SIZE; t++) begin
      rank_flat[t*RANK_W +: RANK_W] = acc;
      acc = acc + RANK_W'(mask[t]);
    end
    total = acc;
  end
endmodule

// File: rtl/compact_lane.sv
module compact_lane #(
  parameter int WARP_SIZE = 32,
  parameter int RANK_W    = 6,
  parameter int SLOT_W    = 7,
  parameter int TID_W     = 5,
  parameter int LANE_IDX  = 0
) (
  input  logic [WARP_SIZE-1:0]        mask,
  input  logic [WARP_SIZE*RANK_W-1:0] rank_flat,
  input  logic [SLOT_W-1:0]           base,
  output logic                        hit,
  output logic [TID_W-1:0]            tid
);
  // Gather: this global lane takes the active thread whose slot matches it.
  always_comb begin
    hit = 1'b0;
    tid = '0;
    for (int t = 0; t < WARP_SIZE; t++) begin
      if (mask[t] &&
          (base + SLOT_W'(rank_flat[t*RANK_W +: RANK_W]) == SLOT_W'(LANE_IDX))) begin
        hit = 1'b1;
        tid = tid | TID_W'(t);
      end
    end
  end
endmodule

// File: rtl/compact_set.sv
module compact_set #(
  parameter int WARP_SIZE = 32,
  parameter int SET_W     = 8,
  parameter int RANK_W    = 6,
  parameter int SLOT_W    = 7,
  parameter int TID_W     = 5,
  parameter int CNT_W     = 4,
  parameter int SET_IDX   = 0
) (
  input  logic [SET_W-1:0]       hits,
  input  logic [SET_W*TID_W-1:0] tids,
  input  logic [RANK_W-1:0]      total,
  input  logic [SLOT_W-1:0]      base,
  output logic [CNT_W-1:0]       count,
  output logic                   valid,
  output logic [WARP_SIZE-1:0]   wpos
);
  localparam int FIRST_SLOT = SET_IDX * SET_W;

  // Count derived arithmetically from total and base, independent of the lane hits.
  always_comb begin
    int avail;
    avail = int'(total) + int'(base) - FIRST_SLOT;
    if (int'(base) > FIRST_SLOT + SET_W - 1) avail = 0;
    if (avail <= 0)          count = '0;
    else if (avail >= SET_W) count = CNT_W'(SET_W);
    else                     count = CNT_W'(avail);
    valid = (count != '0);
  end

  always_comb begin
    wpos = '0;
    for (int l = 0; l < SET_W; l++) begin
      if (hits[l]) wpos[tids[l*TID_W +: TID_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/compact_unit.sv
module compact_unit #(
  parameter int WARP_SIZE = 32,
  parameter int NUM_SETS  = 4,
  parameter int SET_W     = WARP_SIZE / NUM_SETS,
  parameter int TID_W     = compact_pkg::clog2_min1(WARP_SIZE),
  parameter int CNT_W     = compact_pkg::clog2_min1(SET_W + 1),
  parameter int SIDX_W    = compact_pkg::clog2_min1(NUM_SETS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [WARP_SIZE-1:0]            warp_mask,
  input  logic [SIDX_W-1:0]               start_set,
  output logic                            done,
  output logic [NUM_SETS-1:0]             set_valid,
  output logic [NUM_SETS*SET_W-1:0]       lane_mask,
  output logic [NUM_SETS*SET_W*TID_W-1:0] lane_tid,
  output logic [NUM_SETS*CNT_W-1:0]       set_count,
  output logic [NUM_SETS*WARP_SIZE-1:0]   warp_pos,
  output logic                            overflow
);
  localparam int LANES  = NUM_SETS * SET_W;
  localparam int RANK_W = compact_pkg::clog2_min1(WARP_SIZE + 1);
  localparam int SLOT_W = compact_pkg::clog2_min1(2 * LANES + 1);

  logic [WARP_SIZE*RANK_W-1:0] rank_flat;
  logic [RANK_W-1:0]           total;
  logic [SLOT_W-1:0]           base;
  logic [LANES-1:0]            hit_c;
  logic [LANES*TID_W-1:0]      tid_c;
  logic [NUM_SETS*CNT_W-1:0]   cnt_c;
  logic [NUM_SETS-1:0]         val_c;
  logic [NUM_SETS*WARP_SIZE-1:0] wpos_c;
  logic                        ovf_c;

  assign base  = SLOT_W'(start_set) * SLOT_W'(SET_W);
  assign ovf_c = (base + SLOT_W'(total)) > SLOT_W'(LANES);

  compact_rank #(.WARP_SIZE(WARP_SIZE), .RANK_W(RANK_W)) u_rank (
    .mask(warp_mask), .rank_flat(rank_flat), .total(total)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    compact_lane #(
      .WARP_SIZE(WARP_SIZE), .RANK_W(RANK_W), .SLOT_W(SLOT_W),
      .TID_W(TID_W), .LANE_IDX(g)
    ) u_lane (
      .mask(warp_mask), .rank_flat(rank_flat), .base(base),
      .hit(hit_c[g]), .tid(tid_c[g*TID_W +: TID_W])
    );
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    compact_set #(
      .WARP_SIZE(WARP_SIZE), .SET_W(SET_W), .RANK_W(RANK_W), .SLOT_W(SLOT_W),
      .TID_W(TID_W), .CNT_W(CNT_W), .SET_IDX(s)
    ) u_set (
      .hits(hit_c[s*SET_W +: SET_W]),
      .tids(tid_c[s*SET_W*TID_W +: SET_W*TID_W]),
      .total(total), .base(base),
      .count(cnt_c[s*CNT_W +: CNT_W]),
      .valid(val_c[s]),
      .wpos(wpos_c[s*WARP_SIZE +: WARP_SIZE])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      set_valid <= '0;
      lane_mask <= '0;
      lane_tid  <= '0;
      set_count <= '0;
      warp_pos  <= '0;
      overflow  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        set_valid <= val_c;
        lane_mask <= hit_c;
        lane_tid  <= tid_c;
        set_count <= cnt_c;
        warp_pos  <= wpos_c;
        overflow  <= ovf_c;
      end
    end
  end
endmodule

// File: rtl/compact_unit_chk.sv
module compact_unit_chk #(
  parameter int WARP_SIZE = 32,
  parameter int NUM_SETS  = 4,
  parameter int SET_W     = 8,
  parameter int TID_W     = 5,
  parameter int CNT_W     = 4,
  parameter int SIDX_W    = 2
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            start,
  input logic [SIDX_W-1:0]               start_set,
  input logic                            done,
  input logic [NUM_SETS-1:0]             set_valid,
  input logic [NUM_SETS*SET_W-1:0]       lane_mask,
  input logic [NUM_SETS*CNT_W-1:0]       set_count,
  input logic [NUM_SETS*WARP_SIZE-1:0]   warp_pos,
  input logic                            overflow
);
  assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_hold_without_start_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(lane_mask) && $stable(set_count) && $stable(warp_pos));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |-> set_valid[NUM_SETS-1]
                 && set_count[(NUM_SETS-1)*CNT_W +: CNT_W] == CNT_W'(SET_W));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
    assert_count_matches_lanes_R6: assert property (@(posedge clk) disable iff (rst)
      set_count[s*CNT_W +: CNT_W] == CNT_W'($countones(lane_mask[s*SET_W +: SET_W])));
    assert_pos_matches_count_R6: assert property (@(posedge clk) disable iff (rst)
      $countones(warp_pos[s*WARP_SIZE +: WARP_SIZE]) == int'(set_count[s*CNT_W +: CNT_W]));
    assert_valid_iff_filled_R7: assert property (@(posedge clk) disable iff (rst)
      set_valid[s] == (lane_mask[s*SET_W +: SET_W] != '0));
    assert_contiguous_lanes_R5: assert property (@(posedge clk) disable iff (rst)
      ((lane_mask[s*SET_W +: SET_W] & (lane_mask[s*SET_W +: SET_W] + 1'b1)) == '0));
    assert_below_start_empty_R4: assert property (@(posedge clk) disable iff (rst)
      start && (int'(start_set) > s) |=> !set_valid[s]);
  end
endmodule

bind compact_unit compact_unit_chk #(
  .WARP_SIZE(WARP_SIZE), .NUM_SETS(NUM_SETS), .SET_W(SET_W),
  .TID_W(TID_W), .CNT_W(CNT_W), .SIDX_W(SIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .start_set(start_set), .done(done),
  .set_valid(set_valid), .lane_mask(lane_mask), .set_count(set_count),
  .warp_pos(warp_pos), .overflow(overflow)
);

// File: tb/compact_unit_test.sv
`timescale 1ns/1ps
module compact_unit_test;
  localparam int WS = 32, NS = 4, SW = WS / NS, TW = 5, CW = 4, IW = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [WS-1:0] warp_mask = '0;
  logic [IW-1:0] start_set = '0;
  logic done, overflow;
  logic [NS-1:0] set_valid;
  logic [NS*SW-1:0] lane_mask;
  logic [NS*SW*TW-1:0] lane_tid;
  logic [NS*CW-1:0] set_count;
  logic [NS*WS-1:0] warp_pos;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [NS-1:0] e_valid;
  logic [NS*SW-1:0] e_lmask;
  logic [NS*SW*TW-1:0] e_tid;
  logic [NS*CW-1:0] e_cnt;
  logic [NS*WS-1:0] e_wpos;
  logic e_ovf;

  always #5 clk = ~clk;

  compact_unit #(.WARP_SIZE(WS), .NUM_SETS(NS)) uut (
    .clk(clk), .rst(rst), .start(start), .warp_mask(warp_mask),
    .start_set(start_set), .done(done), .set_valid(set_valid),
    .lane_mask(lane_mask), .lane_tid(lane_tid), .set_count(set_count),
    .warp_pos(warp_pos), .overflow(overflow)
  );

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: walk threads in ascending order into global slots (R3, R9).
  task automatic model(input logic [WS-1:0] m, input int ss);
    int slot;
    slot = ss * SW;
    e_valid = '0; e_lmask = '0; e_tid = '0; e_cnt = '0; e_wpos = '0; e_ovf = 1'b0;
    for (int t = 0; t < WS; t++) begin
      if (m[t]) begin
        if (slot >= NS * SW) e_ovf = 1'b1;
        else begin
          e_lmask[slot] = 1'b1;
          e_tid[slot*TW +: TW] = TW'(t);
          e_cnt[(slot/SW)*CW +: CW] = e_cnt[(slot/SW)*CW +: CW] + 1'b1;
          e_wpos[(slot/SW)*WS + t] = 1'b1;
          e_valid[slot/SW] = 1'b1;
        end
        slot++;
      end
    end
  endtask

  task automatic run_case(input string name, input logic [WS-1:0] m, input int ss);
    int direct;
    model(m, ss);
    direct = 0;
    for (int s = 0; s < NS; s++) if (m[s*SW +: SW] != '0) direct++;
    $display("case %s: direct mapping sets=%0d compacted sets=%0d", name, direct,
             $countones(e_valid));
    @(negedge clk);
    warp_mask = m; start_set = IW'(ss); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {name, " done"}, 256'(done), 256'(1'b1));
    check("R3", {name, " lane_tid"}, 256'(lane_tid), 256'(e_tid));
    check("R5", {name, " lane_mask"}, 256'(lane_mask), 256'(e_lmask));
    check("R6", {name, " set_count"}, 256'(set_count), 256'(e_cnt));
    check("R6", {name, " warp_pos"}, 256'(warp_pos), 256'(e_wpos));
    check("R7", {name, " set_valid"}, 256'(set_valid), 256'(e_valid));
    check("R9", {name, " overflow"}, 256'(overflow), 256'(e_ovf));
  endtask

  task automatic test_reset();
    check("R1", "reset valid", 256'(set_valid), 256'(0));
    check("R1", "reset lanes", 256'(lane_mask), 256'(0));
    check("R1", "reset tid", 256'(lane_tid), 256'(0));
    check("R1", "reset pos/count", 256'({warp_pos, set_count}), 256'(0));
    check("R1", "reset done/ovf", 256'({done, overflow}), 256'(0));
  endtask

  task automatic test_hold();
    logic [NS*SW*TW-1:0] keep;
    keep = lane_tid;
    @(negedge clk);
    warp_mask = 32'h0000_0001; start_set = 2'd3;
    @(negedge clk);
    @(negedge clk);
    check("R2", "done drops", 256'(done), 256'(0));
    check("R2", "hold lane_tid", 256'(lane_tid), 256'(keep));
  endtask

  task automatic test_r10_layout();
    // Threads 5 and 9 from set 1: lane 0 of set 1 at slot 8 holds 5, lane 1 holds 9 (R10).
    run_case("layout", 32'h0000_0220, 1);
    check("R10", "set1 lane0 tid", 256'(lane_tid[8*TW +: TW]), 256'(5));
    check("R10", "set1 lane1 tid", 256'(lane_tid[9*TW +: TW]), 256'(9));
    check("R10", "set1 count", 256'(set_count[1*CW +: CW]), 256'(2));
    check("R8", "unused lane tid zero", 256'(lane_tid[10*TW +: TW]), 256'(0));
    check("R4", "set0 below start", 256'({set_valid[0], lane_mask[7:0]}), 256'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    run_case("full_s0", 32'hFFFF_FFFF, 0);
    run_case("sparse_s0", 32'h8421_0F03, 0);
    run_case("sparse_s2_R4", 32'h0101_0101, 2);
    run_case("full_s1_ovf_R9", 32'hFFFF_FFFF, 1);
    run_case("edge_spill_s3", 32'hF00F_0F0F, 3);
    run_case("empty_R7", 32'h0000_0000, 1);
    run_case("top_thread_s3", 32'h8000_0000, 3);
    run_case("alternate_s1", 32'hAAAA_AAAA, 1);
    run_case("exact_fit_s2", 32'h00FF_00FF, 2);
    test_hold();
    test_r10_layout();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule